// File: doc/BRIEF.md
# Speculative Register File with Writer Tags

This block keeps two copies of the integer register state of an out-of-order core. One copy is committed state, written only when instructions retire. The other copy is the speculative state: the newest value of each register, or, if that value is still being computed, the reorder-buffer number of the instruction that will produce it. A small group of scratch registers for multi-step sequences lives in the speculative space only and has no committed copy.

When an instruction issues, it reads its sources from the speculative copy and gets back either a value or a producer tag. It then claims its destination by writing its own tag there and clearing the entry's valid bit. When a result completes, it is written only into the entry that still carries the producer's tag, so only the youngest writer of a register can fill it. A mispredict throws away all speculation in one cycle by copying committed values over the speculative ones. Because of this the reorder buffer is written once and read once per instruction, and it is never searched for operands.

Top module: `spec_regfile`

## Requirements
- R1: After reset every entry, architectural (indices 0..NUM_AREG-1) and scratch (indices NUM_AREG..NUM_AREG+NUM_SCR-1), reads as valid with data 0, and every committed register holds 0.
- R2: Each of the two read ports is combinational on the state held before the current cycle's updates. A valid entry returns `rd_vld_x`=1 and its data. An invalid entry returns `rd_vld_x`=0, and `rd_tag_x` holds the tag recorded for it.
- R3: An issue (`iss_en`=1) to register `iss_reg` makes that entry invalid and records `iss_tag`, visible from the next cycle. `iss_reg` must be below NUM_AREG+NUM_SCR.
- R4: A completion on port p (`cmp_vld[p]`=1) writes `cmp_data[p]` into entry `cmp_reg[p]` and marks it valid from the next cycle. It does so only if that entry is invalid and its recorded tag equals `cmp_tag[p]`. In every other case the completion has no effect.
- R5: When an issue and a completion target the same entry in the same cycle, the issue's tag is recorded, the entry stays invalid, and the completion is dropped.
- R6: A read of an invalid entry whose recorded tag matches a completion to that same register in the same cycle returns valid with the completing data. Port 0 takes priority over port 1.
- R7: A retire (`ret_en`=1) writes `ret_data` into committed register `ret_reg` at the clock edge.
- R8: A mispredict (`flush`=1) makes every architectural entry valid with its committed value, including a retire in the same cycle, from the next cycle on. It overrides any issue or completion in that cycle.
- R9: On a mispredict the scratch entries become valid and keep the data they held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_reg_a | input | RW | Read port A register index |
| rd_vld_a | output | 1 | Read port A value present |
| rd_data_a | output | DATA_W | Read port A value |
| rd_tag_a | output | TAG_W | Read port A producer tag |
| rd_reg_b | input | RW | Read port B register index |
| rd_vld_b | output | 1 | Read port B value present |
| rd_data_b | output | DATA_W | Read port B value |
| rd_tag_b | output | TAG_W | Read port B producer tag |
| iss_en | input | 1 | Issue claims a destination |
| iss_reg | input | RW | Issue destination index |
| iss_tag | input | TAG_W | Issuing instruction's reorder-buffer number |
| cmp_vld | input | NUM_CMP | Completion valid per port |
| cmp_reg | input | NUM_CMP x RW | Completion destination per port |
| cmp_tag | input | NUM_CMP x TAG_W | Completing instruction's number per port |
| cmp_data | input | NUM_CMP x DATA_W | Completion result per port |
| ret_en | input | 1 | Retire write enable |
| ret_reg | input | AW | Retiring architectural register |
| ret_data | input | DATA_W | Retiring value |
| flush | input | 1 | Mispredict: restore speculative state |

## Verification
The bench builds the block with the default 16 architectural and 8 scratch registers and two completion ports, but with a 4-bit tag and 16-bit data. Every register index can then be swept on both read ports, and matching, mismatched and stale tags can be produced with small known numbers. Scratch entries and a retire in the same cycle as a flush sit right next to ordinary traffic. A wrap of the tag space (the same tag held by several registers) comes up in the sweep as well.

// File: rtl/spec_rf_pkg.sv
package spec_rf_pkg;
  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_FLUSH = 2'd1,
    UPD_CLAIM = 2'd2,
    UPD_FILL  = 2'd3
  } upd_e;
endpackage

// File: rtl/spec_rf_commit.sv
module spec_rf_commit #(
  parameter int DATA_W = 32,
  parameter int NUM_AREG = 16,
  localparam int AW = $clog2(NUM_AREG)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ret_en,
  input  logic [AW-1:0]                    ret_reg,
  input  logic [DATA_W-1:0]                ret_data,
  output logic [NUM_AREG-1:0][DATA_W-1:0]  commit_next
);
  logic [NUM_AREG-1:0][DATA_W-1:0] commit_q;

  always_comb begin
    commit_next = commit_q;
    if (ret_en) commit_next[ret_reg] = ret_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) commit_q <= '0;
    else if (ret_en) commit_q <= commit_next;
  end

  AST_RETIRE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    ret_en |=> commit_q[$past(ret_reg)] == $past(ret_data)); // R7
endmodule

// File: rtl/spec_rf_slot.sv
module spec_rf_slot
  import spec_rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W = 7,
  parameter int RW = 5,
  parameter int NUM_CMP = 2,
  parameter int IDX = 0,
  parameter bit HAS_COMMIT = 1'b1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush,
  input  logic [DATA_W-1:0]               commit_val,
  input  logic                            iss_en,
  input  logic [RW-1:0]                   iss_reg,
  input  logic [TAG_W-1:0]                iss_tag,
  input  logic [NUM_CMP-1:0]              cmp_vld,
  input  logic [NUM_CMP-1:0][RW-1:0]      cmp_reg,
  input  logic [NUM_CMP-1:0][TAG_W-1:0]   cmp_tag,
  input  logic [NUM_CMP-1:0][DATA_W-1:0]  cmp_data,
  output logic                            vld_q,
  output logic [TAG_W-1:0]                tag_q,
  output logic [DATA_W-1:0]               data_q
);
  localparam logic [RW-1:0] MY_IDX = RW'(IDX);

  upd_e              upd;
  logic              fill_hit;
  logic [DATA_W-1:0] fill_data;
  logic [DATA_W-1:0] data_n;
  logic [TAG_W-1:0]  tag_n;
  logic              vld_n;
  logic              upd_en;

  always_comb begin
    fill_hit  = 1'b0;
    fill_data = '0;
    for (int p = NUM_CMP - 1; p >= 0; p--) begin
      if (cmp_vld[p] && cmp_reg[p] == MY_IDX && cmp_tag[p] == tag_q) begin
        fill_hit  = 1'b1;
        fill_data = cmp_data[p];
      end
    end
  end

  always_comb begin
    if (flush)                          upd = UPD_FLUSH;
    else if (iss_en && iss_reg == MY_IDX) upd = UPD_CLAIM;
    else if (!vld_q && fill_hit)        upd = UPD_FILL;
    else                                upd = UPD_HOLD;
  end

  always_comb begin
    data_n = data_q;
    tag_n  = tag_q;
    vld_n  = vld_q;
    unique case (upd)
      UPD_FLUSH: begin
        vld_n = 1'b1;
        if (HAS_COMMIT) data_n = commit_val;
      end
      UPD_CLAIM: begin
        vld_n = 1'b0;
        tag_n = iss_tag;
      end
      UPD_FILL: begin
        vld_n  = 1'b1;
        data_n = fill_data;
      end
      default: ;
    endcase
  end

  assign upd_en = (upd != UPD_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b1;
      tag_q  <= '0;
      data_q <= '0;
    end else if (upd_en) begin
      vld_q  <= vld_n;
      tag_q  <= tag_n;
      data_q <= data_n;
    end
  end

  AST_CLAIM_STAMPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && iss_en && iss_reg == MY_IDX) |=> (!vld_q && tag_q == $past(iss_tag))); // R3

  AST_NO_MATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !(iss_en && iss_reg == MY_IDX) && (vld_q || !fill_hit))
      |=> ($stable(vld_q) && $stable(data_q) && $stable(tag_q))); // R4

  AST_FLUSH_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && HAS_COMMIT) |=> (vld_q && data_q == $past(commit_val))); // R8

  AST_SCRATCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !HAS_COMMIT) |=> (vld_q && $stable(data_q))); // R9
endmodule

// File: rtl/spec_rf_rdport.sv
module spec_rf_rdport #(
  parameter int DATA_W = 32,
  parameter int TAG_W = 7,
  parameter int RW = 5,
  parameter int NUM_REG = 24,
  parameter int NUM_CMP = 2
) (
  input  logic [RW-1:0]                   rd_reg,
  input  logic [NUM_REG-1:0]              ent_vld,
  input  logic [NUM_REG-1:0][TAG_W-1:0]   ent_tag,
  input  logic [NUM_REG-1:0][DATA_W-1:0]  ent_data,
  input  logic [NUM_CMP-1:0]              cmp_vld,
  input  logic [NUM_CMP-1:0][RW-1:0]      cmp_reg,
  input  logic [NUM_CMP-1:0][TAG_W-1:0]   cmp_tag,
  input  logic [NUM_CMP-1:0][DATA_W-1:0]  cmp_data,
  output logic                            rd_vld,
  output logic [DATA_W-1:0]               rd_data,
  output logic [TAG_W-1:0]                rd_tag
);
  logic              sel_vld;
  logic [TAG_W-1:0]  sel_tag;
  logic [DATA_W-1:0] sel_data;

  always_comb begin
    sel_vld  = 1'b1;
    sel_tag  = '0;
    sel_data = '0;
    for (int r = 0; r < NUM_REG; r++) begin
      if (rd_reg == RW'(r)) begin
        sel_vld  = ent_vld[r];
        sel_tag  = ent_tag[r];
        sel_data = ent_data[r];
      end
    end
  end

  always_comb begin
    rd_vld  = sel_vld;
    rd_tag  = sel_tag;
    rd_data = sel_data;
    for (int p = NUM_CMP - 1; p >= 0; p--) begin
      if (!sel_vld && cmp_vld[p] && cmp_reg[p] == rd_reg && cmp_tag[p] == sel_tag) begin
        rd_vld  = 1'b1;
        rd_data = cmp_data[p];
      end
    end
  end
endmodule

// File: rtl/spec_regfile.sv
module spec_regfile #(
  parameter int DATA_W = 32,
  parameter int TAG_W = 7,
  parameter int NUM_AREG = 16,
  parameter int NUM_SCR = 8,
  parameter int NUM_CMP = 2,
  localparam int NUM_REG = NUM_AREG + NUM_SCR,
  localparam int RW = $clog2(NUM_REG),
  localparam int AW = $clog2(NUM_AREG)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [RW-1:0]                   rd_reg_a,
  output logic                            rd_vld_a,
  output logic [DATA_W-1:0]               rd_data_a,
  output logic [TAG_W-1:0]                rd_tag_a,
  input  logic [RW-1:0]                   rd_reg_b,
  output logic                            rd_vld_b,
  output logic [DATA_W-1:0]               rd_data_b,
  output logic [TAG_W-1:0]                rd_tag_b,
  input  logic                            iss_en,
  input  logic [RW-1:0]                   iss_reg,
  input  logic [TAG_W-1:0]                iss_tag,
  input  logic [NUM_CMP-1:0]              cmp_vld,
  input  logic [NUM_CMP-1:0][RW-1:0]      cmp_reg,
  input  logic [NUM_CMP-1:0][TAG_W-1:0]   cmp_tag,
  input  logic [NUM_CMP-1:0][DATA_W-1:0]  cmp_data,
  input  logic                            ret_en,
  input  logic [AW-1:0]                   ret_reg,
  input  logic [DATA_W-1:0]               ret_data,
  input  logic                            flush
);
  logic [NUM_AREG-1:0][DATA_W-1:0] commit_next;
  logic [NUM_REG-1:0]              ent_vld;
  logic [NUM_REG-1:0][TAG_W-1:0]   ent_tag;
  logic [NUM_REG-1:0][DATA_W-1:0]  ent_data;

  spec_rf_commit #(.DATA_W(DATA_W), .NUM_AREG(NUM_AREG)) i_commit (
    .clk(clk), .rst_n(rst_n), .ret_en(ret_en), .ret_reg(ret_reg),
    .ret_data(ret_data), .commit_next(commit_next)
  );

  for (genvar r = 0; r < NUM_REG; r++) begin : g_slot
    logic [DATA_W-1:0] restore_val;
    if (r < NUM_AREG) begin : g_arch
      assign restore_val = commit_next[r];
    end else begin : g_scr
      assign restore_val = '0;
    end
    spec_rf_slot #(
      .DATA_W(DATA_W), .TAG_W(TAG_W), .RW(RW), .NUM_CMP(NUM_CMP),
      .IDX(r), .HAS_COMMIT(r < NUM_AREG)
    ) i_slot (
      .clk(clk), .rst_n(rst_n), .flush(flush), .commit_val(restore_val),
      .iss_en(iss_en), .iss_reg(iss_reg), .iss_tag(iss_tag),
      .cmp_vld(cmp_vld), .cmp_reg(cmp_reg), .cmp_tag(cmp_tag), .cmp_data(cmp_data),
      .vld_q(ent_vld[r]), .tag_q(ent_tag[r]), .data_q(ent_data[r])
    );
  end

  spec_rf_rdport #(
    .DATA_W(DATA_W), .TAG_W(TAG_W), .RW(RW), .NUM_REG(NUM_REG), .NUM_CMP(NUM_CMP)
  ) i_rd_a (
    .rd_reg(rd_reg_a), .ent_vld(ent_vld), .ent_tag(ent_tag), .ent_data(ent_data),
    .cmp_vld(cmp_vld), .cmp_reg(cmp_reg), .cmp_tag(cmp_tag), .cmp_data(cmp_data),
    .rd_vld(rd_vld_a), .rd_data(rd_data_a), .rd_tag(rd_tag_a)
  );

  spec_rf_rdport #(
    .DATA_W(DATA_W), .TAG_W(TAG_W), .RW(RW), .NUM_REG(NUM_REG), .NUM_CMP(NUM_CMP)
  ) i_rd_b (
    .rd_reg(rd_reg_b), .ent_vld(ent_vld), .ent_tag(ent_tag), .ent_data(ent_data),
    .cmp_vld(cmp_vld), .cmp_reg(cmp_reg), .cmp_tag(cmp_tag), .cmp_data(cmp_data),
    .rd_vld(rd_vld_b), .rd_data(rd_data_b), .rd_tag(rd_tag_b)
  );

  AST_CLAIM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_en |-> (iss_reg < RW'(NUM_REG))); // R3

  AST_FLUSH_ALL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (&ent_vld)); // R8
endmodule

// File: tb/test_spec_regfile.sv
module test_spec_regfile;
  localparam int DW = 16;
  localparam int TW = 4;
  localparam int NA = 16;
  localparam int NS = 8;
  localparam int NR = NA + NS;
  localparam int RW = 5;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RW-1:0] rd_reg_a = '0, rd_reg_b = '0;
  logic rd_vld_a, rd_vld_b;
  logic [DW-1:0] rd_data_a, rd_data_b;
  logic [TW-1:0] rd_tag_a, rd_tag_b;
  logic iss_en = 1'b0;
  logic [RW-1:0] iss_reg = '0;
  logic [TW-1:0] iss_tag = '0;
  logic [1:0] cmp_vld = '0;
  logic [1:0][RW-1:0] cmp_reg = '0;
  logic [1:0][TW-1:0] cmp_tag = '0;
  logic [1:0][DW-1:0] cmp_data = '0;
  logic ret_en = 1'b0;
  logic [AW-1:0] ret_reg = '0;
  logic [DW-1:0] ret_data = '0;
  logic flush = 1'b0;

  always #2 clk = ~clk;

  spec_regfile #(.DATA_W(DW), .TAG_W(TW), .NUM_AREG(NA), .NUM_SCR(NS), .NUM_CMP(2)) i_spec_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd_reg_a(rd_reg_a), .rd_vld_a(rd_vld_a), .rd_data_a(rd_data_a), .rd_tag_a(rd_tag_a),
    .rd_reg_b(rd_reg_b), .rd_vld_b(rd_vld_b), .rd_data_b(rd_data_b), .rd_tag_b(rd_tag_b),
    .iss_en(iss_en), .iss_reg(iss_reg), .iss_tag(iss_tag),
    .cmp_vld(cmp_vld), .cmp_reg(cmp_reg), .cmp_tag(cmp_tag), .cmp_data(cmp_data),
    .ret_en(ret_en), .ret_reg(ret_reg), .ret_data(ret_data), .flush(flush)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_data [NR];
  logic          m_vld  [NR];
  logic [TW-1:0] m_tag  [NR];
  logic [DW-1:0] m_com  [NA];

  task automatic chk_port(input string req, input int r, input logic av, input logic [DW-1:0] ad,
                          input logic [TW-1:0] at);
    logic ev;
    logic [DW-1:0] ed;
    ev = m_vld[r];
    ed = m_data[r];
    if (!ev) begin
      for (int p = 1; p >= 0; p--)
        if (cmp_vld[p] && cmp_reg[p] == RW'(r) && cmp_tag[p] == m_tag[r]) begin
          ev = 1'b1;
          ed = cmp_data[p];
        end
    end
    checks++;
    if (av !== ev || (ev && ad !== ed) || (!ev && at !== m_tag[r])) begin
      errors++;
      $display("FAIL %s reg %0d: vld/data/tag %0b/%0h/%0h expected %0b/%0h/%0h",
               req, r, av, ad, at, ev, ed, m_tag[r]);
    end
  endtask

  task automatic step(input string req);
    logic [DW-1:0] nd [NR];
    logic          nv [NR];
    logic [TW-1:0] nt [NR];
    logic [DW-1:0] nc [NA];
    #1;
    chk_port(req, int'(rd_reg_a), rd_vld_a, rd_data_a, rd_tag_a);
    chk_port(req, int'(rd_reg_b), rd_vld_b, rd_data_b, rd_tag_b);
    for (int r = 0; r < NA; r++) nc[r] = m_com[r];
    if (ret_en) nc[ret_reg] = ret_data;
    for (int r = 0; r < NR; r++) begin
      nd[r] = m_data[r]; nv[r] = m_vld[r]; nt[r] = m_tag[r];
      if (flush) begin
        nv[r] = 1'b1;
        if (r < NA) nd[r] = nc[r];
      end else if (iss_en && iss_reg == RW'(r)) begin
        nv[r] = 1'b0;
        nt[r] = iss_tag;
      end else if (!m_vld[r]) begin
        for (int p = 1; p >= 0; p--)
          if (cmp_vld[p] && cmp_reg[p] == RW'(r) && cmp_tag[p] == m_tag[r]) begin
            nv[r] = 1'b1;
            nd[r] = cmp_data[p];
          end
      end
    end
    @(posedge clk);
    for (int r = 0; r < NR; r++) begin m_data[r] = nd[r]; m_vld[r] = nv[r]; m_tag[r] = nt[r]; end
    for (int r = 0; r < NA; r++) m_com[r] = nc[r];
    #1;
    iss_en = 1'b0; cmp_vld = '0; ret_en = 1'b0; flush = 1'b0;
  endtask

  task automatic read_all(input string req);
    for (int r = 0; r < NR; r += 2) begin
      rd_reg_a = RW'(r);
      rd_reg_b = RW'(NR - 1 - r);
      step(req);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: run incomplete, actual hung expected finished");
    finish_run();
  end

  initial begin
    for (int r = 0; r < NR; r++) begin m_data[r] = '0; m_vld[r] = 1'b1; m_tag[r] = '0; end
    for (int r = 0; r < NA; r++) m_com[r] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: reset state of every entry on both ports
    read_all("R1");

    // R3 R7: claim each register with a wrapping tag, retire architectural values meanwhile
    for (int r = 0; r < NR; r++) begin
      iss_en = 1'b1; iss_reg = RW'(r); iss_tag = TW'(r % 16);
      if (r < NA) begin ret_en = 1'b1; ret_reg = AW'(r); ret_data = DW'(r * 3 + 1); end
      rd_reg_a = RW'(r); rd_reg_b = RW'(r);
      step("R2");
    end
    read_all("R3");

    // R4: mismatched tags on both completion ports leave entries untouched
    for (int r = 0; r < NR; r++) begin
      cmp_vld = 2'b11;
      cmp_reg[0] = RW'(r); cmp_tag[0] = TW'((r + 1) % 16); cmp_data[0] = 16'hdead;
      cmp_reg[1] = RW'(r); cmp_tag[1] = TW'((r + 5) % 16); cmp_data[1] = 16'hbeef;
      rd_reg_a = RW'(r); rd_reg_b = RW'((r + 1) % NR);
      step("R4");
    end
    read_all("R4");

    // R6 R4: matching completions alternate ports, read bypassed the same cycle
    for (int r = 0; r < NR; r++) begin
      cmp_vld = (r % 2 == 0) ? 2'b01 : 2'b10;
      cmp_reg[r % 2] = RW'(r); cmp_tag[r % 2] = TW'(r % 16); cmp_data[r % 2] = DW'(r * 7 + 5);
      rd_reg_a = RW'(r); rd_reg_b = RW'(r);
      step("R6");
    end
    read_all("R4");

    // R6: both ports match; port 0 data must be taken
    iss_en = 1'b1; iss_reg = 5'd6; iss_tag = 4'd11; step("R3");
    cmp_vld = 2'b11;
    cmp_reg[0] = 5'd6; cmp_tag[0] = 4'd11; cmp_data[0] = 16'h1111;
    cmp_reg[1] = 5'd6; cmp_tag[1] = 4'd11; cmp_data[1] = 16'h2222;
    rd_reg_a = 5'd6; rd_reg_b = 5'd6;
    step("R6");
    step("R6");

    // R5: claim and completion to the same entry in one cycle
    iss_en = 1'b1; iss_reg = 5'd3; iss_tag = 4'd5; step("R3");
    iss_en = 1'b1; iss_reg = 5'd3; iss_tag = 4'd9;
    cmp_vld = 2'b01; cmp_reg[0] = 5'd3; cmp_tag[0] = 4'd5; cmp_data[0] = 16'h0abc;
    rd_reg_a = 5'd3; rd_reg_b = 5'd3;
    step("R5");
    step("R5");
    cmp_vld = 2'b10; cmp_reg[1] = 5'd3; cmp_tag[1] = 4'd9; cmp_data[1] = 16'h0def;
    step("R5");
    step("R5");

    // R8 R9: claim a mix, then flush with a same-cycle retire and claim
    for (int r = 0; r < NR; r += 3) begin
      iss_en = 1'b1; iss_reg = RW'(r); iss_tag = TW'(15 - (r % 16)); step("R3");
    end
    flush = 1'b1; ret_en = 1'b1; ret_reg = 4'd2; ret_data = 16'h7777;
    iss_en = 1'b1; iss_reg = 5'd9; iss_tag = 4'd1;
    cmp_vld = 2'b01; cmp_reg[0] = 5'd0; cmp_tag[0] = 4'd15; cmp_data[0] = 16'h4444;
    step("R8");
    read_all("R8");
    read_all("R9");

    // R4: stale completion after flush, entry valid with same stored tag
    cmp_vld = 2'b01; cmp_reg[0] = 5'd3; cmp_tag[0] = 4'd12; cmp_data[0] = 16'h5555;
    rd_reg_a = 5'd3; rd_reg_b = 5'd0;
    step("R4");
    step("R4");

    // R7: retire all architectural registers, restore by flush and read back
    for (int r = 0; r < NA; r++) begin
      ret_en = 1'b1; ret_reg = AW'(r); ret_data = DW'(16'h9000 + r * 17);
      iss_en = 1'b1; iss_reg = RW'(r); iss_tag = TW'(r);
      step("R7");
    end
    flush = 1'b1; step("R7");
    read_all("R7");

    finish_run();
  end
endmodule